// File: doc/BRIEF.md
# Saturating Vector Arithmetic Shifter

This block is the arithmetic shift datapath of a DSP core. It takes a 32-bit operand and a signed shift count. A positive count shifts left and a negative count shifts right by its magnitude. The operand can be treated in four ways:

- a single 16-bit lane in the low half;
- a single 16-bit lane in the high half;
- one 32-bit word;
- two independent 16-bit lanes.

Right shifts always fill with the sign bit. Left shifts either drop the bits that leave the top, or, when saturation is enabled, clamp any lane whose signed value would not survive the shift.

The answer is registered. A request presented with `in_valid` appears one clock later on `result`, together with `out_valid` and an overflow flag that reports a clamp in any active lane. Between requests the output register holds its last value.

Top module: `sat_vec_shifter`

## Requirements
- R1: A negative count shifts right by its magnitude and fills vacated upper bits with copies of the lane's sign bit. A magnitude at or beyond the lane width (16 or 32) yields all sign bits. A right shift never raises `ovf`.
- R2: In vector mode (`mode` = 2'b11), bits [31:16] and bits [15:0] are shifted independently by the same count, and no bit moves between them.
- R3: In word mode (`mode` = 2'b10), all 32 bits are shifted as one signed value, so bits cross the half-word boundary.
- R4: With `sat_en` low, a left shift keeps the low lane-width bits of the shifted value, discards the rest, and leaves `ovf` low.
- R5: With `sat_en` high, a left shift whose true signed result does not fit the lane clamps that lane. A negative input clamps to the most negative value (0x80000000 for a word, 0x8000 for a lane). A non-negative input clamps to the most positive value (0x7FFFFFFF or 0x7FFF). `ovf` is high when any active lane clamps.
- R6: With `sat_en` high, a left shift whose result fits the lane gives the same value as the unsaturated shift, with `ovf` low.
- R7: Half modes shift only the selected lane, with their own saturation; the other half of `result` equals the operand's half unchanged. In `mode` 2'b00 the low lane [15:0] is shifted. In `mode` 2'b01 the high lane [31:16] is shifted.
- R8: `count` is a 6-bit two's-complement value (−32 to +31). Zero passes the lanes unchanged.
- R9: `result` and `ovf` update on the clock edge that samples `in_valid` high, and `out_valid` is high in the following cycle. When `in_valid` is low, `out_valid` falls and `result` and `ovf` hold.
- R10: A synchronous active-high `rst` clears `out_valid`, `result` and `ovf` on the next clock edge, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 32 | Value to shift |
| count | input | 6 | Signed shift count, positive = left |
| mode | input | 2 | 00 low lane, 01 high lane, 10 word, 11 vector |
| sat_en | input | 1 | Saturate left shifts |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 32 | Registered shifted value |
| ovf | output | 1 | Some active lane saturated |

## Verification
In vector mode one lane can clamp while the other shifts cleanly in the same cycle, and the flag must still reflect the clamping lane. The same applies when one lane clamps high and the other sits at its most negative value without overflowing. These cases are provoked by directed operands whose halves have opposite signs and different headroom, followed by a long run of random operands, counts, modes and saturation settings. A reset that arrives together with a valid request is also driven, and reset must win. Every cycle is judged against a behavioural model that computes each lane's exact product as an integer and compares it with the lane's range, rather than inspecting dropped bits.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef enum logic [1:0] {
    MODE_HALF_LO = 2'b00,
    MODE_HALF_HI = 2'b01,
    MODE_WORD    = 2'b10,
    MODE_VEC     = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/lane_shift.sv
// One signed lane: left shift with optional clamp, right shift with sign fill.
module lane_shift #(
  parameter int W  = 16,
  parameter int CW = 6
) (
  input  logic [W-1:0]  x,
  input  logic [CW-1:0] cnt,
  input  logic          sat_en,
  output logic [W-1:0]  y,
  output logic          sat
);
  localparam int XW = W + 2**(CW-1);
  localparam logic [W-1:0] LANE_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] LANE_MAX = {1'b0, {(W-1){1'b1}}};

  logic          neg;
  logic [CW-1:0] mag;
  logic [XW-1:0] wide;
  logic [XW-W:0] top;
  logic          lost;
  logic signed [W-1:0] xs;
  logic signed [W-1:0] rsh;

  assign neg  = cnt[CW-1];
  assign mag  = neg ? (~cnt + 1'b1) : cnt;
  assign wide = {{(XW-W){x[W-1]}}, x} << mag;
  assign top  = wide[XW-1:W-1];
  assign lost = !((&top) || !(|top));
  assign xs   = x;
  assign rsh  = xs >>> mag;

  always_comb begin
    sat = 1'b0;
    if (neg) begin
      y = rsh;
    end else if (sat_en && lost) begin
      sat = 1'b1;
      y   = x[W-1] ? LANE_MIN : LANE_MAX;
    end else begin
      y = wide[W-1:0];
    end
  end
endmodule

// File: rtl/shift_core.sv
// Builds the word lane and the half lanes, then selects by mode.
module shift_core
  import shifter_pkg::*;
#(
  parameter int DW = 32,
  parameter int HW = 16,
  parameter int CW = 6
) (
  input  logic [DW-1:0] operand,
  input  logic [CW-1:0] count,
  input  shift_mode_e   mode,
  input  logic          sat_en,
  output logic [DW-1:0] res,
  output logic          ovf
);
  localparam int LANES = DW / HW;

  logic [DW-1:0] w_y;
  logic          w_s;
  logic [HW-1:0] h_y [LANES];
  logic          h_s [LANES];

  lane_shift #(.W(DW), .CW(CW)) u_word (
    .x(operand), .cnt(count), .sat_en(sat_en), .y(w_y), .sat(w_s)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_half
    lane_shift #(.W(HW), .CW(CW)) u_half (
      .x(operand[g*HW +: HW]), .cnt(count), .sat_en(sat_en),
      .y(h_y[g]), .sat(h_s[g])
    );
  end

  always_comb begin
    res = operand;
    ovf = 1'b0;
    unique case (mode)
      MODE_HALF_LO: begin
        res[HW-1:0] = h_y[0];
        ovf         = h_s[0];
      end
      MODE_HALF_HI: begin
        res[DW-1 -: HW] = h_y[LANES-1];
        ovf             = h_s[LANES-1];
      end
      MODE_WORD: begin
        res = w_y;
        ovf = w_s;
      end
      default: begin
        for (int i = 0; i < LANES; i++) begin
          res[i*HW +: HW] = h_y[i];
          ovf             = ovf | h_s[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/out_stage.sv
// Output register with synchronous reset and hold when idle.
module out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_in,
  input  logic [DW-1:0] d_res,
  input  logic          d_ovf,
  output logic          vld_out,
  output logic [DW-1:0] q_res,
  output logic          q_ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_out <= 1'b0;
      q_res   <= '0;
      q_ovf   <= 1'b0;
    end else begin
      vld_out <= vld_in;
      if (vld_in) begin
        q_res <= d_res;
        q_ovf <= d_ovf;
      end
    end
  end
endmodule

// File: rtl/sat_vec_shifter.sv
module sat_vec_shifter
  import shifter_pkg::*;
#(
  parameter int DW = 32,
  parameter int HW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] operand,
  input  logic [CW-1:0] count,
  input  logic [1:0]    mode,
  input  logic          sat_en,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          ovf
);
  logic [DW-1:0] c_res;
  logic          c_ovf;

  shift_core #(.DW(DW), .HW(HW), .CW(CW)) u_core (
    .operand(operand), .count(count), .mode(shift_mode_e'(mode)),
    .sat_en(sat_en), .res(c_res), .ovf(c_ovf)
  );

  out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .vld_in(in_valid), .d_res(c_res), .d_ovf(c_ovf),
    .vld_out(out_valid), .q_res(result), .q_ovf(ovf)
  );
endmodule

// File: rtl/sat_shifter_chk.sv
module sat_shifter_chk #(
  parameter int DW = 32,
  parameter int HW = 16,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [DW-1:0] operand,
  input logic [CW-1:0] count,
  input logic [1:0]    mode,
  input logic          sat_en,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic          ovf
);
  localparam logic [DW-1:0] WMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] WMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [HW-1:0] HMAX = {1'b0, {(HW-1){1'b1}}};
  localparam logic [HW-1:0] HMIN = {1'b1, {(HW-1){1'b0}}};

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(ovf)));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && !ovf && result == '0));

  assert_no_ovf_unsat_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_en) |=> !ovf);

  assert_no_ovf_right_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && count[CW-1]) |=> !ovf);

  assert_clamp_value_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ovf) |->
      (result == WMAX || result == WMIN ||
       result[HW-1:0] == HMAX || result[HW-1:0] == HMIN ||
       result[DW-1 -: HW] == HMAX || result[DW-1 -: HW] == HMIN));

  assert_low_lane_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00) |=> (result[DW-1:HW] == $past(operand[DW-1:HW])));

  assert_high_lane_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01) |=> (result[DW-HW-1:0] == $past(operand[DW-HW-1:0])));
endmodule

bind sat_vec_shifter sat_shifter_chk #(.DW(DW), .HW(HW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
  .count(count), .mode(mode), .sat_en(sat_en), .out_valid(out_valid),
  .result(result), .ovf(ovf)
);

// File: tb/sim_sat_vec_shifter.sv
`timescale 1ns/1ps
module sim_sat_vec_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [5:0]  count = '0;
  logic [1:0]  mode = '0;
  logic        sat_en = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_valid = 0;
  logic [31:0] exp_res = '0;
  bit exp_ovf = 0;

  always #4 clk = ~clk;

  sat_vec_shifter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .count(count), .mode(mode), .sat_en(sat_en), .out_valid(out_valid),
    .result(result), .ovf(ovf)
  );

  // Integer model of one lane: exact product compared against lane range.
  function automatic void ref_lane(input longint x, input int w, input int c,
                                   input bit sat, output longint y, output bit o);
    longint mask, v, hi, lo, p;
    mask = (longint'(1) << w) - 1;
    v = x & mask;
    if (((v >> (w - 1)) & 1) == 1) v = v - (longint'(1) << w);
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    o = 0;
    if (c >= 0) begin
      p = v * (longint'(1) << c);
      if (sat && (p > hi || p < lo)) begin
        o = 1;
        p = (p > hi) ? hi : lo;
      end
    end else if (-c >= w) begin
      p = (v < 0) ? -1 : 0;
    end else begin
      p = v >>> (-c);
    end
    y = p & mask;
  endfunction

  function automatic void ref_word(input logic [31:0] op, input logic [5:0] cn,
                                   input logic [1:0] md, input bit s);
    int c;
    longint ya, yb;
    bit oa, ob;
    c = int'($signed(cn));
    case (md)
      2'b00: begin
        ref_lane(longint'(op[15:0]), 16, c, s, ya, oa);
        exp_res = {op[31:16], ya[15:0]}; exp_ovf = oa;
      end
      2'b01: begin
        ref_lane(longint'(op[31:16]), 16, c, s, ya, oa);
        exp_res = {ya[15:0], op[15:0]}; exp_ovf = oa;
      end
      2'b10: begin
        ref_lane(longint'(op), 32, c, s, ya, oa);
        exp_res = ya[31:0]; exp_ovf = oa;
      end
      default: begin
        ref_lane(longint'(op[31:16]), 16, c, s, ya, oa);
        ref_lane(longint'(op[15:0]), 16, c, s, yb, ob);
        exp_res = {ya[15:0], yb[15:0]}; exp_ovf = oa | ob;
      end
    endcase
  endfunction

  task automatic step(input bit r, input bit v, input logic [31:0] op,
                      input logic [5:0] cn, input logic [1:0] md, input bit s,
                      input string tag);
    rst = r; in_valid = v; operand = op; count = cn; mode = md; sat_en = s;
    if (r) begin
      exp_valid = 0; exp_res = '0; exp_ovf = 0;
    end else if (v) begin
      exp_valid = 1;
      ref_word(op, cn, md, s);
    end else begin
      exp_valid = 0;
    end
    @(negedge clk);
    n_cmp++;
    if (out_valid !== exp_valid || result !== exp_res || ovf !== exp_ovf) begin
      n_bad++;
      $display("FAIL %s: valid=%0b result=%h ovf=%0b expected valid=%0b result=%h ovf=%0b",
               tag, out_valid, result, ovf, exp_valid, exp_res, exp_ovf);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1, 1, 32'hFFFF_FFFF, 6'd1, 2'b10, 1, "R10");
    step(1, 0, 32'h0, 6'd0, 2'b00, 0, "R10");
    // R1 sign fill and long right shifts
    step(0, 1, 32'h0000_80F0, -6'sd1, 2'b00, 0, "R1");
    step(0, 1, 32'h80F0_0000, -6'sd2, 2'b01, 1, "R1");
    step(0, 1, 32'h8000_0000, -6'sd32, 2'b10, 1, "R1");
    step(0, 1, 32'h0000_7000, -6'sd20, 2'b00, 0, "R1");
    step(0, 1, 32'h1234_8000, -6'sd16, 2'b00, 1, "R1");
    // R2 vector lanes
    step(0, 1, 32'h1000_1000, -6'sd1, 2'b11, 0, "R2");
    step(0, 1, 32'h80F0_80F0, -6'sd2, 2'b11, 0, "R2");
    step(0, 1, 32'h0001_8000, 6'd1, 2'b11, 0, "R2");
    // R3 word crosses halves
    step(0, 1, 32'h80F0_80F0, -6'sd3, 2'b10, 0, "R3");
    step(0, 1, 32'h1000_1000, -6'sd4, 2'b10, 0, "R3");
    // R4 unsaturated left
    step(0, 1, 32'hC80F_E00F, 6'd4, 2'b10, 0, "R4");
    step(0, 1, 32'h0000_C00F, 6'd1, 2'b00, 0, "R4");
    step(0, 1, 32'h7FFF_FFFF, 6'd31, 2'b10, 0, "R4");
    // R5 clamps
    step(0, 1, 32'hC80F_E00F, 6'd4, 2'b10, 1, "R5");
    step(0, 1, 32'hFFFF_FFF4, 6'd31, 2'b10, 1, "R5");
    step(0, 1, 32'h3000_0003, 6'd2, 2'b10, 1, "R5");
    step(0, 1, 32'h0000_800F, 6'd1, 2'b00, 1, "R5");
    step(0, 1, 32'h4000_C000, 6'd1, 2'b11, 1, "R5");
    step(0, 1, 32'h0001_0000, 6'd20, 2'b11, 1, "R5");
    // R6 saturation without clamp
    step(0, 1, 32'hF80F_E00F, 6'd4, 2'b10, 1, "R6");
    step(0, 1, 32'hE00F_E00F, 6'd2, 2'b11, 1, "R6");
    step(0, 1, 32'hFFFF_FFFF, 6'd31, 2'b10, 1, "R6");
    // R7 half lanes
    step(0, 1, 32'h800F_1234, 6'd1, 2'b01, 1, "R7");
    step(0, 1, 32'hABCD_0001, 6'd3, 2'b00, 1, "R7");
    step(0, 1, 32'hC00F_5555, 6'd1, 2'b01, 1, "R7");
    // R8 signed count
    step(0, 1, 32'h3000_0003, 6'd2, 2'b10, 0, "R8");
    step(0, 1, 32'h3000_0003, 6'd0, 2'b11, 1, "R8");
    step(0, 1, 32'h1234_5678, -6'sd1, 2'b10, 0, "R8");
    // R9 hold while idle
    step(0, 0, 32'hDEAD_BEEF, 6'd5, 2'b10, 1, "R9");
    step(0, 0, 32'h0, -6'sd3, 2'b11, 0, "R9");
    // R10 reset with a valid request
    step(0, 1, 32'h4000_0000, 6'd3, 2'b10, 1, "R10");
    step(1, 1, 32'h4000_0000, 6'd3, 2'b10, 1, "R10");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 97) == 0, ($urandom % 4) != 0, $urandom,
           6'($urandom), 2'($urandom), 1'($urandom), "R9");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule